// File: doc/BRIEF.md
# Clock-Request Pin Function Controller

This block manages two shared pads. After reset each pad drives a free-running clock. Under register control a pad can instead become an active-low clock-request input. In that role it gates one of two selectable differential clock pairs. The block guards the switch between the two roles. A pad enters request mode only if its clock driver was already turned off when the request bit was written. If software gets the order wrong, the pad keeps driving and a sticky error flag is raised.

Configuration arrives as single-byte writes. Each write is an address/data strobe, decoded by the same byte offsets that a serial management agent would use. Request inputs pass through a two-flop synchronizer in the register clock domain. Each of the four gated pairs then retimes its enable on the falling edge of its own clock. A pair is therefore only cut or restored while its clock is low. The block also holds the function-select bit that moves pair 0 between its default SRC role and a 96 MHz dot-clock role.

Top module: `crq_pin_ctrl`

## Requirements
- R1: After reset both bits of `pin_oe` are 1, `req_mode` and `req_err` are 0, `pair0_dot` is 0 and all four gated pairs pass their clocks.
- R2: Writing address 5 with bit 7 (pad A) or bit 5 (pad B) set to 1 puts that pad in request mode from the next cycle. This happens only if the pad's output-enable bit (address 2, bit 0 for pad A, bit 1 for pad B) is 0 and the pad has no pending error.
- R3: Address 5 bit 6 selects the pair that pad A steers: 0 selects gate index 0 and 1 selects gate index 2. Bit 4 selects the pair for pad B: 0 selects index 1 and 1 selects index 3.
- R4: Writing a pad's request bit as 1 while that pad drives as a clock output (output-enable bit 1, not in request mode) leaves it in output mode and sets its `req_err`. The flag stays set, and later writes of 1 have no effect, until a write of 0 to that request bit clears it.
- R5: A request input at 1 (deasserted) holds its selected pair's output low, and a 0 lets the pair run. A pair that no pad in request mode selects always runs.
- R6: While a pad is in request mode its `pin_oe` is 0, whatever its output-enable bit holds.
- R7: Address 1 bit 7 drives `pair0_dot` (1 = dot-clock function for pair 0).
- R8: A gated pair's enable changes only on a falling edge of that pair's clock, so a high phase that has started is never cut short.
- R9: Writes to addresses other than 1, 2 and 5, and writes to unused bits of those bytes, change no output.
- R10: A change on a request input reaches its pair no earlier than after two rising register-clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and synchronizer clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 8 | Byte written |
| pin_req_n | input | 2 | Pad input levels, active-low requests (bit 0 pad A) |
| pair_clk_in | input | 4 | Ungated clocks of the four controllable pairs |
| pin_oe | output | 2 | Pad clock-driver enables |
| req_mode | output | 2 | 1 when the pad acts as request input |
| req_err | output | 2 | Sticky ordering error per pad |
| pair0_dot | output | 1 | Pair 0 function: 0 SRC, 1 dot clock |
| pair_clk_out | output | 4 | Gated pair clocks |

## Verification
The checker watches the register-side rules on every cycle. It confirms that request mode is never entered while the pad driver was on, that a guarded write always leaves an error, that an error and request mode never coexist, that the function bit follows its byte, and that writes to other addresses change nothing. The bench scenarios cover what depends on clock phase and on the pad inputs. These are the two-edge synchronizer delay, a full high phase surviving after the synchronized request drops, pair steering for both select values, and uncontrolled pairs running while a request stays deasserted.

// File: rtl/crq_pkg.sv
package crq_pkg;

    localparam int NUM_PINS  = 2;
    localparam int NUM_PAIRS = 4;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam int SYNC_LEN  = 2;

    localparam logic [ADDR_W-1:0] ADDR_FUNC = 8'd1;
    localparam logic [ADDR_W-1:0] ADDR_OE   = 8'd2;
    localparam logic [ADDR_W-1:0] ADDR_REQ  = 8'd5;
    localparam int                DOT_BIT   = 7;

    typedef struct packed {
        logic [NUM_PINS-1:0] oe;
        logic [NUM_PINS-1:0] req;
        logic [NUM_PINS-1:0] sel;
        logic [NUM_PINS-1:0] blk;
        logic                dot;
    } cfg_t;

    // bit of the request byte that enables request mode for a pad
    function automatic int req_bit(input int pin);
        return 7 - 2 * pin;
    endfunction

    // bit of the request byte that picks the steered pair for a pad
    function automatic int sel_bit(input int pin);
        return 6 - 2 * pin;
    endfunction

    // gate index steered by a pad for a given select value
    function automatic int target_pair(input int pin, input logic sel);
        return pin + (sel ? NUM_PINS : 0);
    endfunction

endpackage

// File: rtl/crq_regs.sv
module crq_regs
    import crq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_t              cfg
);

    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            cfg_q.oe  <= '1;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_FUNC: cfg_q.dot <= wr_data[DOT_BIT];
                ADDR_OE: begin
                    for (int i = 0; i < NUM_PINS; i++)
                        cfg_q.oe[i] <= wr_data[i];
                end
                ADDR_REQ: begin
                    for (int i = 0; i < NUM_PINS; i++) begin
                        cfg_q.req[i] <= wr_data[req_bit(i)];
                        cfg_q.sel[i] <= wr_data[sel_bit(i)];
                        if (!wr_data[req_bit(i)])
                            cfg_q.blk[i] <= 1'b0;
                        else if (cfg_q.oe[i] && !(cfg_q.req[i] && !cfg_q.blk[i]))
                            cfg_q.blk[i] <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/crq_sync.sv
module crq_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/crq_route.sv
module crq_route
    import crq_pkg::*;
(
    input  logic [NUM_PINS-1:0]  mode,
    input  logic [NUM_PINS-1:0]  sel,
    input  logic [NUM_PINS-1:0]  req_n_s,
    output logic [NUM_PAIRS-1:0] pair_en
);

    always_comb begin
        pair_en = '1;
        for (int p = 0; p < NUM_PAIRS; p++)
            for (int i = 0; i < NUM_PINS; i++)
                if (mode[i] && req_n_s[i] && target_pair(i, sel[i]) == p)
                    pair_en[p] = 1'b0;
    end

endmodule

// File: rtl/crq_gate.sv
module crq_gate #(
    parameter int N = 4
) (
    input  logic         rst,
    input  logic [N-1:0] clk_in,
    input  logic [N-1:0] en,
    output logic [N-1:0] clk_out
);

    for (genvar p = 0; p < N; p++) begin : g_pair
        logic en_q;
        always_ff @(negedge clk_in[p]) begin
            if (rst) en_q <= 1'b1;
            else     en_q <= en[p];
        end
        assign clk_out[p] = clk_in[p] & en_q;
    end

endmodule

// File: rtl/crq_pin_ctrl.sv
module crq_pin_ctrl
    import crq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [NUM_PINS-1:0]  pin_req_n,
    input  logic [NUM_PAIRS-1:0] pair_clk_in,
    output logic [NUM_PINS-1:0]  pin_oe,
    output logic [NUM_PINS-1:0]  req_mode,
    output logic [NUM_PINS-1:0]  req_err,
    output logic                 pair0_dot,
    output logic [NUM_PAIRS-1:0] pair_clk_out
);

    cfg_t                 cfg;
    logic [NUM_PINS-1:0]  mode;
    logic [NUM_PINS-1:0]  req_n_s;
    logic [NUM_PAIRS-1:0] pair_en;

    crq_regs i_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    crq_sync #(.W(NUM_PINS), .STAGES(SYNC_LEN)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_req_n),
        .q   (req_n_s)
    );

    assign mode = cfg.req & ~cfg.blk;

    crq_route i_route (
        .mode    (mode),
        .sel     (cfg.sel),
        .req_n_s (req_n_s),
        .pair_en (pair_en)
    );

    crq_gate #(.N(NUM_PAIRS)) i_gate (
        .rst     (rst),
        .clk_in  (pair_clk_in),
        .en      (pair_en),
        .clk_out (pair_clk_out)
    );

    assign pin_oe    = cfg.oe & ~mode;
    assign req_mode  = mode;
    assign req_err   = cfg.blk;
    assign pair0_dot = cfg.dot;

endmodule

// File: rtl/crq_pin_ctrl_chk.sv
module crq_pin_ctrl_chk
    import crq_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic [DATA_W-1:0]   wr_data,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_PINS-1:0] req_mode,
    input logic [NUM_PINS-1:0] req_err,
    input logic                pair0_dot
);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        assert_oe_off_first_R2: assert property (@(posedge clk) disable iff (rst)
            $rose(req_mode[i]) |-> !$past(pin_oe[i]));

        assert_guard_sets_err_R4: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_addr == ADDR_REQ && wr_data[req_bit(i)] && pin_oe[i])
            |=> (req_err[i] && !req_mode[i]));

        assert_err_excludes_mode_R4: assert property (@(posedge clk) disable iff (rst)
            req_err[i] |-> !req_mode[i]);
    end

    assert_dot_follows_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_FUNC) |=> (pair0_dot == $past(wr_data[DOT_BIT])));

    assert_other_addr_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != ADDR_FUNC && wr_addr != ADDR_OE && wr_addr != ADDR_REQ)
        |=> ($stable(pin_oe) && $stable(req_mode) && $stable(req_err) && $stable(pair0_dot)));

endmodule

bind crq_pin_ctrl crq_pin_ctrl_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .pin_oe    (pin_oe),
    .req_mode  (req_mode),
    .req_err   (req_err),
    .pair0_dot (pair0_dot)
);

// File: tb/test_crq_pin_ctrl.sv
module test_crq_pin_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] pin_req_n = 2'b00;
    logic [1:0] pin_oe, req_mode, req_err;
    logic       pair0_dot;
    logic [3:0] pair_clk_out;

    int n_total = 0;
    int n_pass  = 0;
    bit done    = 1'b0;

    string      tag_q[$];
    logic [10:0] exp_q[$];

    always #10 clk = ~clk;

    crq_pin_ctrl i_crq_pin_ctrl (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .pin_req_n    (pin_req_n),
        .pair_clk_in  ({4{clk}}),
        .pin_oe       (pin_oe),
        .req_mode     (req_mode),
        .req_err      (req_err),
        .pair0_dot    (pair0_dot),
        .pair_clk_out (pair_clk_out)
    );

    // expected item layout: {oe[1:0], mode[1:0], err[1:0], dot, gate[3:0]}
    task automatic push_now(input string tag, input logic [1:0] oe, input logic [1:0] md,
                            input logic [1:0] er, input logic dt, input logic [3:0] gt);
        tag_q.push_back(tag);
        exp_q.push_back({oe, md, er, dt, gt});
    endtask

    task automatic expect_settled(input string tag, input logic [1:0] oe, input logic [1:0] md,
                                  input logic [1:0] er, input logic dt, input logic [3:0] gt);
        repeat (3) @(posedge clk);
        push_now(tag, oe, md, er, dt, gt);
    endtask

    task automatic write_byte(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // monitor: samples mid-way through the high phase of every cycle
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                string       t;
                logic [10:0] e, a;
                t = tag_q.pop_front();
                e = exp_q.pop_front();
                a = {pin_oe, req_mode, req_err, pair0_dot, pair_clk_out};
                n_total++;
                if (a === e) n_pass++;
                else $display("FAIL %s: actual %b expected %b", t, a, e);
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        expect_settled("R1 reset state", 2'b11, 2'b00, 2'b00, 1'b0, 4'b1111);

        write_byte(8'd5, 8'h80);
        expect_settled("R4 request while driving", 2'b11, 2'b00, 2'b01, 1'b0, 4'b1111);
        write_byte(8'd2, 8'h02);
        expect_settled("R4 error sticky after disable", 2'b10, 2'b00, 2'b01, 1'b0, 4'b1111);
        write_byte(8'd5, 8'h80);
        expect_settled("R4 rewrite ignored while error", 2'b10, 2'b00, 2'b01, 1'b0, 4'b1111);
        write_byte(8'd5, 8'h00);
        expect_settled("R4 clear by zero write", 2'b10, 2'b00, 2'b00, 1'b0, 4'b1111);
        write_byte(8'd5, 8'h80);
        expect_settled("R2 enter request mode", 2'b10, 2'b01, 2'b00, 1'b0, 4'b1111);

        write_byte(8'd2, 8'h03);
        expect_settled("R6 driver held off in request mode", 2'b10, 2'b01, 2'b00, 1'b0, 4'b1111);
        write_byte(8'd2, 8'h02);

        @(negedge clk) pin_req_n[0] = 1'b1;
        @(posedge clk) push_now("R10 one edge no effect", 2'b10, 2'b01, 2'b00, 1'b0, 4'b1111);
        @(posedge clk) push_now("R8 high phase kept", 2'b10, 2'b01, 2'b00, 1'b0, 4'b1111);
        @(posedge clk) push_now("R5 pair 0 stopped", 2'b10, 2'b01, 2'b00, 1'b0, 4'b1110);

        @(negedge clk) pin_req_n[0] = 1'b0;
        expect_settled("R5 pair 0 restarted", 2'b10, 2'b01, 2'b00, 1'b0, 4'b1111);

        write_byte(8'd5, 8'hC0);
        @(negedge clk) pin_req_n[0] = 1'b1;
        expect_settled("R3 pad A steers index 2", 2'b10, 2'b01, 2'b00, 1'b0, 4'b1011);

        write_byte(8'd2, 8'h00);
        write_byte(8'd5, 8'hF0);
        @(negedge clk) pin_req_n[1] = 1'b1;
        expect_settled("R3 pad B steers index 3", 2'b00, 2'b11, 2'b00, 1'b0, 4'b0011);
        @(negedge clk) pin_req_n[1] = 1'b0;
        expect_settled("R5 pad B request asserted", 2'b00, 2'b11, 2'b00, 1'b0, 4'b1011);

        write_byte(8'd3, 8'hFF);
        expect_settled("R9 unmapped address", 2'b00, 2'b11, 2'b00, 1'b0, 4'b1011);
        write_byte(8'd1, 8'h7F);
        expect_settled("R9 unused function bits", 2'b00, 2'b11, 2'b00, 1'b0, 4'b1011);
        write_byte(8'd1, 8'h80);
        expect_settled("R7 dot function selected", 2'b00, 2'b11, 2'b00, 1'b1, 4'b1011);

        write_byte(8'd5, 8'h00);
        expect_settled("R5 uncontrolled pairs run", 2'b00, 2'b00, 2'b00, 1'b1, 4'b1111);

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_total++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_pass, n_total);
            $finish;
        end
    end

endmodule